// File: doc/BRIEF.md
# Flow-Control Status Calendar Sequencer

On the receive side of a packet link, this block reports the fill state of up to 16 port FIFOs back to the transmitter. It sends one port status per clock on a 2-bit status channel. A programmable calendar table sets the order of the ports, so a port may appear once, several times or not at all. A change in a port's status is not pushed out when it happens. It goes out the next time the calendar reaches that port.

Each sequence begins with a one-cycle framing code. The calendar slots follow, and the whole calendar repeats a programmed number of times. The sequence closes with a one-cycle parity word that covers every slot that was sent. The calendar length and the repeat count are taken only in the framing cycle, so they can be changed safely at any time. Calendar entries can be written only while the block is disabled.

The status channel runs freely and has no back-pressure. A word appears on every clock and is held for exactly one cycle, so a consumer must accept a word on every clock. The outputs are combinational from internal state and from the port status vector. Each slot therefore carries the status the port has in that same cycle.

Top module: `fc_status_calendar`

## Requirements
- R1: From the cycle after `en` is sampled low, `stat_out` is 2'b11 and `slot_idx` is 0 on every cycle until the block is re-enabled.
- R2: While enabled, each sequence is one framing cycle (2'b11), then len×reps slot cycles, then one parity cycle, then the next framing cycle. The period is len×reps+2 clocks.
- R3: In slot k of a repetition, `slot_idx` is k and `stat_out` is the status of port cal[k]. That status is taken from `port_status[2p+1:2p]` for port p in the same cycle, so a change made just after a port's slot appears only at that port's next slot.
- R4: Status codes are 2'b00 starving, 2'b01 hungry and 2'b10 satisfied. A port input of 2'b11 is sent as 2'b10, so a slot never carries the framing code.
- R5: Within one sequence, the ordered list of slots is sent reps times back to back, with `slot_idx` running 0..len-1 in each repetition.
- R6: The parity word is the bitwise XOR of every slot word sent in that sequence, across all repetitions. A sequence with no slots gives a parity of 2'b00.
- R7: `cfg_len` and `cfg_reps` are sampled only at the edge that leaves the framing cycle. A change made during a sequence takes effect in the next sequence.
- R8: A calendar length of 0 is treated as 1 and a length above 16 is treated as 16. A repeat count of 0 is treated as 1 and a repeat count above 4 is treated as 4.
- R9: A calendar write (`cal_wr_en`, entry `cal_wr_addr` gets port `cal_wr_port`) takes effect only when `en` is low. Writes made while enabled leave the table unchanged.
- R10: After reset, calendar entry i holds port i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run the calendar; low holds the framing code |
| port_status | input | 32 | 2-bit current status per port, port p at bits 2p+1:2p |
| cal_wr_en | input | 1 | Write one calendar entry (only while disabled) |
| cal_wr_addr | input | 4 | Calendar entry to write |
| cal_wr_port | input | 4 | Port number stored in that entry |
| cfg_len | input | 5 | Calendar length, 1 to 16 |
| cfg_reps | input | 3 | Repetitions per sequence, 1 to 4 |
| stat_out | output | 2 | Status channel word |
| slot_idx | output | 4 | Calendar position of the current slot, 0 outside slots |

## Verification
A wrong slot position or repetition count shifts the place of the framing and parity words. The mismatch shows on `stat_out` within one sequence, at most 66 clocks. A corrupt calendar entry or a wrong port lookup shows as a wrong port's status in that slot, seen the first time the bench drives different statuses on the two ports. A wrong parity accumulator is exposed at the parity cycle of the sequence in which it goes wrong. A configuration latched at the wrong moment changes the length of the sequence that follows. The bench compares both outputs against a reference on every clock, so each of these faults is reported in the cycle where it first shows.

// File: rtl/calseq_pkg.sv
`timescale 1ns/1ps
package calseq_pkg;
  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SLOT = 2'd1,
    PH_PAR  = 2'd2
  } phase_e;

  localparam logic [1:0] ST_STARVE = 2'b00;
  localparam logic [1:0] ST_HUNGRY = 2'b01;
  localparam logic [1:0] ST_SATISF = 2'b10;
  localparam logic [1:0] ST_FRAME  = 2'b11;

  // the framing code is reserved; a port reporting it is sent as satisfied
  function automatic logic [1:0] clean_status(input logic [1:0] s);
    return (s == ST_FRAME) ? ST_SATISF : s;
  endfunction
endpackage

// File: rtl/calseq_table.sv
`timescale 1ns/1ps
module calseq_table
  import calseq_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int CAL_MAX   = 16,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int IDX_W    = $clog2(CAL_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_allow,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [PORT_W-1:0] rd_port
);
  logic [CAL_MAX-1:0][PORT_W-1:0] entries;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CAL_MAX; i++) entries[i] <= PORT_W'(i % NUM_PORTS);
    end else if (wr_allow && wr_en && (wr_addr <= IDX_W'(CAL_MAX - 1))) begin
      entries[wr_addr] <= wr_port;
    end
  end

  assign rd_port = entries[rd_addr];

  // R9: a write while enabled leaves the table untouched
  p_wr_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |=> $stable(entries));
endmodule

// File: rtl/calseq_ctrl.sv
`timescale 1ns/1ps
module calseq_ctrl
  import calseq_pkg::*;
#(
  parameter int CAL_MAX  = 16,
  parameter int MAX_REPS = 4,
  localparam int IDX_W   = $clog2(CAL_MAX),
  localparam int LEN_W   = $clog2(CAL_MAX + 1),
  localparam int RPT_W   = $clog2(MAX_REPS + 1),
  localparam int RC_W    = $clog2(MAX_REPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [RPT_W-1:0] cfg_reps,
  output phase_e           phase,
  output logic [IDX_W-1:0] pos
);
  logic [LEN_W-1:0] act_len, len_c;
  logic [RPT_W-1:0] act_reps, reps_c;
  logic [RC_W-1:0]  rep;
  logic             last_pos, last_rep;

  always_comb begin
    if (cfg_len == '0)                     len_c = LEN_W'(1);
    else if (cfg_len > LEN_W'(CAL_MAX))    len_c = LEN_W'(CAL_MAX);
    else                                   len_c = cfg_len;
    if (cfg_reps == '0)                    reps_c = RPT_W'(1);
    else if (cfg_reps > RPT_W'(MAX_REPS))  reps_c = RPT_W'(MAX_REPS);
    else                                   reps_c = cfg_reps;
  end

  assign last_pos = (LEN_W'(pos) == act_len - LEN_W'(1));
  assign last_rep = (RPT_W'(rep) == act_reps - RPT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_SYNC;
      pos      <= '0;
      rep      <= '0;
      act_len  <= LEN_W'(1);
      act_reps <= RPT_W'(1);
    end else begin
      unique case (phase)
        PH_SYNC: begin
          act_len  <= len_c;
          act_reps <= reps_c;
          pos      <= '0;
          rep      <= '0;
          if (en) phase <= PH_SLOT;
        end
        PH_SLOT: begin
          if (!en) begin
            phase <= PH_SYNC;
          end else if (last_pos) begin
            pos <= '0;
            if (last_rep) phase <= PH_PAR;
            else          rep   <= rep + RC_W'(1);
          end else begin
            pos <= pos + IDX_W'(1);
          end
        end
        PH_PAR:  phase <= PH_SYNC;
        default: phase <= PH_SYNC;
      endcase
    end
  end

  p_disable_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> phase == PH_SYNC);
  p_par_then_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_PAR |=> phase == PH_SYNC);
  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SLOT |-> LEN_W'(pos) < act_len);
  p_rep_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SLOT |-> RPT_W'(rep) < act_reps);
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_SYNC |=> ($stable(act_len) && $stable(act_reps)));
  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SLOT |-> (act_len >= LEN_W'(1) && act_len <= LEN_W'(CAL_MAX)
                          && act_reps >= RPT_W'(1) && act_reps <= RPT_W'(MAX_REPS)));
endmodule

// File: rtl/calseq_parity.sv
`timescale 1ns/1ps
module calseq_parity
  import calseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase,
  input  logic [1:0] word,
  output logic [1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acc <= 2'b00;
    else if (phase == PH_SYNC)  acc <= 2'b00;
    else if (phase == PH_SLOT)  acc <= acc ^ word;
  end

  p_par_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SYNC |=> acc == 2'b00);
endmodule

// File: rtl/fc_status_calendar.sv
`timescale 1ns/1ps
module fc_status_calendar
  import calseq_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int CAL_MAX   = 16,
  parameter int MAX_REPS  = 4,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int IDX_W    = $clog2(CAL_MAX),
  localparam int LEN_W    = $clog2(CAL_MAX + 1),
  localparam int RPT_W    = $clog2(MAX_REPS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [2*NUM_PORTS-1:0] port_status,
  input  logic                   cal_wr_en,
  input  logic [IDX_W-1:0]       cal_wr_addr,
  input  logic [PORT_W-1:0]      cal_wr_port,
  input  logic [LEN_W-1:0]       cfg_len,
  input  logic [RPT_W-1:0]       cfg_reps,
  output logic [1:0]             stat_out,
  output logic [IDX_W-1:0]       slot_idx
);
  phase_e            phase;
  logic [IDX_W-1:0]  pos;
  logic [PORT_W-1:0] slot_port;
  logic [1:0]        slot_word, par_acc;
  logic [NUM_PORTS-1:0][1:0] lane_clean;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
    assign lane_clean[p] = clean_status(port_status[2*p +: 2]);
  end

  calseq_ctrl #(.CAL_MAX(CAL_MAX), .MAX_REPS(MAX_REPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_len(cfg_len), .cfg_reps(cfg_reps),
    .phase(phase), .pos(pos)
  );

  calseq_table #(.NUM_PORTS(NUM_PORTS), .CAL_MAX(CAL_MAX)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_allow(!en),
    .wr_en(cal_wr_en), .wr_addr(cal_wr_addr), .wr_port(cal_wr_port),
    .rd_addr(pos), .rd_port(slot_port)
  );

  assign slot_word = lane_clean[slot_port];

  calseq_parity u_par (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .word(slot_word), .acc(par_acc)
  );

  always_comb begin
    unique case (phase)
      PH_SLOT: stat_out = slot_word;
      PH_PAR:  stat_out = par_acc;
      default: stat_out = ST_FRAME;
    endcase
    slot_idx = (phase == PH_SLOT) ? pos : '0;
  end

  p_slot_not_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SLOT |-> stat_out != ST_FRAME);
  p_idle_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (stat_out == ST_FRAME && slot_idx == '0));
endmodule

// File: tb/sim_fc_status_calendar.sv
`timescale 1ns/1ps
module sim_fc_status_calendar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] port_status = '0;
  logic        cal_wr_en = 1'b0;
  logic [3:0]  cal_wr_addr = '0;
  logic [3:0]  cal_wr_port = '0;
  logic [4:0]  cfg_len = 5'd1;
  logic [2:0]  cfg_reps = 3'd1;
  logic [1:0]  stat_out;
  logic [3:0]  slot_idx;

  fc_status_calendar u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .port_status(port_status),
    .cal_wr_en(cal_wr_en), .cal_wr_addr(cal_wr_addr), .cal_wr_port(cal_wr_port),
    .cfg_len(cfg_len), .cfg_reps(cfg_reps),
    .stat_out(stat_out), .slot_idx(slot_idx)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string req    = "R10";

  // reference model, written from the requirements
  int         m_ph;   // 0 framing, 1 slot, 2 parity
  int         m_pos, m_rep, m_len, m_reps;
  logic [1:0] m_acc;
  logic [3:0] m_cal [16];

  function automatic int cl_len(input int v);
    return (v == 0) ? 1 : ((v > 16) ? 16 : v);
  endfunction
  function automatic int cl_reps(input int v);
    return (v == 0) ? 1 : ((v > 4) ? 4 : v);
  endfunction
  function automatic logic [1:0] fix(input logic [1:0] s);
    return (s == 2'b11) ? 2'b10 : s;
  endfunction
  function logic [1:0] exp_word();
    if (m_ph == 1) return fix(port_status[{m_cal[m_pos], 1'b0} +: 2]);
    if (m_ph == 2) return m_acc;
    return 2'b11;
  endfunction
  function logic [3:0] exp_idx();
    return (m_ph == 1) ? 4'(m_pos) : 4'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pos = 0; m_rep = 0; m_len = 1; m_reps = 1; m_acc = 2'b00;
      for (int i = 0; i < 16; i++) m_cal[i] = 4'(i);
    end else begin
      logic [1:0] w;
      w = exp_word();
      if (!en && cal_wr_en) m_cal[cal_wr_addr] = cal_wr_port;
      case (m_ph)
        0: begin
          m_acc = 2'b00; m_len = cl_len(cfg_len); m_reps = cl_reps(cfg_reps);
          m_pos = 0; m_rep = 0;
          if (en) m_ph = 1;
        end
        1: begin
          m_acc = m_acc ^ w;
          if (!en) m_ph = 0;
          else if (m_pos == m_len - 1) begin
            m_pos = 0;
            if (m_rep == m_reps - 1) m_ph = 2; else m_rep = m_rep + 1;
          end else m_pos = m_pos + 1;
        end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (stat_out !== exp_word() || slot_idx !== exp_idx()) begin
        fails++;
        $display("FAIL %s: stat_out=%0d slot_idx=%0d expected stat_out=%0d slot_idx=%0d",
                 req, stat_out, slot_idx, exp_word(), exp_idx());
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      if (rnd) port_status = $urandom();
      tick();
    end
  endtask

  task automatic wr(input int a, input int p);
    cal_wr_en = 1'b1; cal_wr_addr = 4'(a); cal_wr_port = 4'(p);
    tick();
    cal_wr_en = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    // R10: reset state and identity calendar
    repeat (3) tick();
    rst_n = 1'b1;
    req = "R1"; run(5, 1'b1);
    req = "R10"; cfg_len = 5'd16; cfg_reps = 3'd1; en = 1'b1; run(40, 1'b1);
    req = "R1"; en = 1'b0; run(6, 1'b1);
    // R5: repeated short calendar with a port listed twice
    req = "R5";
    wr(0, 3); wr(1, 3); wr(2, 7); wr(3, 0); wr(4, 15);
    cfg_len = 5'd5; cfg_reps = 3'd3; en = 1'b1; run(60, 1'b1);
    req = "R6"; run(51, 1'b1);
    // R4: every port reports the reserved code, then a mixed fixed pattern
    req = "R4"; port_status = 32'hFFFF_FFFF; run(30, 1'b0);
    port_status = 32'hE4E4_1B1B; run(20, 1'b0);
    // R7: change configuration in the middle of a sequence
    req = "R7"; cfg_len = 5'd9; cfg_reps = 3'd2; run(50, 1'b1);
    cfg_len = 5'd2; run(7, 1'b1); cfg_reps = 3'd4; run(40, 1'b1);
    // R8: out-of-range length and repeat values
    req = "R8"; en = 1'b0; tick(); cfg_len = 5'd0; cfg_reps = 3'd0; en = 1'b1; run(20, 1'b1);
    en = 1'b0; tick(); cfg_len = 5'd31; cfg_reps = 3'd7; en = 1'b1; run(140, 1'b1);
    // R9: writes while enabled are dropped
    req = "R9"; cfg_len = 5'd4; cfg_reps = 3'd1;
    wr(0, 9); wr(1, 9); wr(2, 9); wr(3, 9); run(20, 1'b1);
    en = 1'b0; tick(); en = 1'b1; run(40, 1'b1);
    // R2: minimal sequence, fixed statuses
    req = "R2"; en = 1'b0; tick(); cfg_len = 5'd1; cfg_reps = 3'd1;
    port_status = 32'h5555_5555; en = 1'b1; run(15, 1'b0);
    cfg_reps = 3'd2; port_status = 32'hAAAA_AAA8; run(20, 1'b0);
    // R3: random calendars, configurations and enable drops
    req = "R3";
    for (int k = 0; k < 40; k++) begin
      en = 1'b0; tick();
      for (int j = 0; j < 4; j++) wr($urandom_range(0, 15), $urandom_range(0, 15));
      cfg_len = 5'($urandom_range(0, 20)); cfg_reps = 3'($urandom_range(0, 5));
      en = 1'b1;
      run($urandom_range(10, 160), 1'b1);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog (%s): actual=running expected=finished", req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule